// File: doc/BRIEF.md
# Oscillator Enable and Ready Controller

This block is the control register for two clock oscillators: an internal RC oscillator and an external crystal oscillator. Software reaches it through a simple word-wide bus. The register holds an enable bit for each oscillator, a ready flag for each, a user trim field, and a factory calibration byte.

Hardware rules sit on top of software writes. A write cannot switch off an oscillator while that oscillator feeds the system clock, either directly or through the PLL. The same holds while the oscillator is the source selected to take over. Low-power events force the enables:
- entry into a stop state switches the crystal off;
- a wake-up switches the RC on;
- a crystal failure switches the RC on while the crystal is in use.

After the RC is disabled, its ready flag stays up for a fixed number of RC clock ticks before it falls. Bus accesses complete at once, except while a clock-source switch is under way. In that case the access is stretched by wait states.

The analog oscillators are modelled by stabilisation inputs. The clock mux is modelled by source-select inputs. The RC clock is modelled by a tick strobe.

Top module: `osc_ctrl`

## Requirements
- R1: After reset the RC enable reads 1, the crystal enable reads 0, the trim field reads 16, both ready flags read 0, and bit 2 reads 0.
- R2: The register layout is as follows:
  - bit 0: RC enable;
  - bit 1: RC ready (read-only);
  - bit 2: reads 0;
  - bits 7:3: trim;
  - bits 15:8: calibration (read-only);
  - bit 16: crystal enable;
  - bit 17: crystal ready (read-only);
  - bits 31:18: read 0.

  With no switch in progress, `ack_o` rises in the same cycle as `req_i`, and a write takes effect at that clock edge.
- R3: A write of 0 to bit 0 leaves the RC enabled when the RC is in use. The RC is in use when either `sys_sel_i` or `tgt_sel_i` is internal (00), or is PLL (10) with `pll_src_ext_i`=0.
- R4: A write of 0 to bit 16 leaves the crystal enabled when the crystal is in use. The crystal is in use when either select is external (01), or is PLL (10) with `pll_src_ext_i`=1.
- R5: A `stop_i` pulse clears the crystal enable at the next edge, even when the crystal is in use.
- R6: A `wake_i` pulse sets the RC enable at the next edge. So does an `osc_fail_i` pulse while the crystal feeds the system clock. Either event wins over a software clear of bit 0 in the same cycle.
- R7: The RC ready flag follows the RC stabilisation input 3 edges after that input changes, while the RC is enabled. After the RC enable falls, the flag falls on the 6th `int_tick_i` edge. It holds while no ticks arrive.
- R8: The crystal ready flag follows the crystal stabilisation input after 2 edges, and is 0 whenever the crystal enable is 0.
- R9: The calibration byte is captured from `cal_i` on the first edge after reset, and writes cannot change it. `trim_sum_o` equals calibration plus trim as a 9-bit sum with no wrap.
- R10: An access that begins while `sw_busy_i` is high receives exactly 2 wait states. It is acknowledged on its third cycle, and a write takes effect only at that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, held until acknowledged |
| we_i | input | 1 | Write strobe qualifying `req_i` |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register read data |
| ack_o | output | 1 | Access acknowledge |
| sw_busy_i | input | 1 | Clock-source switch in progress |
| sys_sel_i | input | 2 | Active system clock source: 00 RC, 01 crystal, 10 PLL |
| tgt_sel_i | input | 2 | Source selected to become system clock, same encoding |
| pll_src_ext_i | input | 1 | PLL reference is the crystal (1) or the RC (0) |
| stop_i | input | 1 | Stop/standby entry pulse |
| wake_i | input | 1 | Stop/standby exit pulse |
| osc_fail_i | input | 1 | Crystal failure pulse |
| int_stab_i | input | 1 | RC stabilised (asynchronous) |
| ext_stab_i | input | 1 | Crystal stabilised (asynchronous) |
| int_tick_i | input | 1 | One strobe per RC oscillator cycle |
| cal_i | input | 8 | Factory calibration value |
| int_en_o | output | 1 | RC enable |
| ext_en_o | output | 1 | Crystal enable |
| int_rdy_o | output | 1 | RC ready flag |
| ext_rdy_o | output | 1 | Crystal ready flag |
| trim_sum_o | output | 9 | Calibration plus trim |

## Verification
Results are due at the following points:
- The acknowledge is combinational in the request cycle, or in the third cycle during a switch.
- Enable changes from writes and events appear one edge after the acknowledge or pulse.
- Crystal ready appears two edges after its input changes, and RC ready three edges after.
- RC ready falls on the sixth tick edge after the enable drops.

The bench drives inputs on the falling edge and samples on the following falling edge. It counts edges from the acknowledging edge, so every check falls exactly in the cycle named above. Near-exhaustive sweeps cover all trim codes and every combination of active source, target source and PLL reference.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;
  localparam logic [1:0] SRC_INT = 2'b00;
  localparam logic [1:0] SRC_EXT = 2'b01;
  localparam logic [1:0] SRC_PLL = 2'b10;

  localparam int unsigned BIT_INT_EN  = 0;
  localparam int unsigned BIT_INT_RDY = 1;
  localparam int unsigned TRIM_LSB    = 3;
  localparam int unsigned CAL_LSB     = 8;
  localparam int unsigned BIT_EXT_EN  = 16;
  localparam int unsigned BIT_EXT_RDY = 17;

  // true when source s consumes the requested oscillator (want_ext)
  function automatic logic src_uses(input logic [1:0] s, input logic pll_ext, input logic want_ext);
    case (s)
      SRC_INT: return !want_ext;
      SRC_EXT: return want_ext;
      SRC_PLL: return pll_ext == want_ext;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic osc_locked(input logic [1:0] sys, input logic [1:0] tgt,
                                      input logic pll_ext, input logic want_ext);
    return src_uses(sys, pll_ext, want_ext) || src_uses(tgt, pll_ext, want_ext);
  endfunction
endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sq[i] <= 1'b0;
      else if (i == 0) sq[i] <= d_i;
      else             sq[i] <= sq[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/osc_bus_port.sv
module osc_bus_port #(
  parameter int unsigned WAIT_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic ack_o
);
  localparam int unsigned CW = (WAIT_N > 1) ? $clog2(WAIT_N) : 1;

  logic          pend_q;
  logic [CW-1:0] cnt_q;

  assign ack_o = req_i && (pend_q ? (cnt_q == '0) : !busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!pend_q) begin
      if (req_i && busy_i) begin
        pend_q <= 1'b1;
        cnt_q  <= CW'(WAIT_N - 1);
      end
    end else if (cnt_q == '0) begin
      pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/osc_en_rules.sv
module osc_en_rules
  import osc_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       wr_int_i,
  input  logic       wr_ext_i,
  input  logic [1:0] sys_sel_i,
  input  logic [1:0] tgt_sel_i,
  input  logic       pll_src_ext_i,
  input  logic       stop_i,
  input  logic       wake_i,
  input  logic       fail_i,
  output logic       int_en_o,
  output logic       ext_en_o
);
  logic int_lock, ext_lock, ext_live, int_force;

  assign int_lock  = osc_locked(sys_sel_i, tgt_sel_i, pll_src_ext_i, 1'b0);
  assign ext_lock  = osc_locked(sys_sel_i, tgt_sel_i, pll_src_ext_i, 1'b1);
  assign ext_live  = src_uses(sys_sel_i, pll_src_ext_i, 1'b1);
  assign int_force = wake_i || (fail_i && ext_live);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_o <= 1'b1;
      ext_en_o <= 1'b0;
    end else begin
      if (int_force)  int_en_o <= 1'b1;
      else if (wr_i)  int_en_o <= wr_int_i || int_lock;
      if (stop_i)     ext_en_o <= 1'b0;
      else if (wr_i)  ext_en_o <= wr_ext_i || ext_lock;
    end
  end
endmodule

// File: rtl/osc_rdy_hold.sv
module osc_rdy_hold #(
  parameter int unsigned DLY = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stab_i,
  input  logic tick_i,
  output logic rdy_o
);
  localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_o <= 1'b0;
      cnt_q <= '0;
    end else if (en_i) begin
      rdy_o <= stab_i;
      cnt_q <= '0;
    end else if (rdy_o && tick_i) begin
      if (cnt_q == CW'(DLY - 1)) begin
        rdy_o <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osc_ctrl.sv
module osc_ctrl
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CAL_W     = 8,
  parameter int unsigned TRIM_W    = 5,
  parameter int unsigned TRIM_RST  = 16,
  parameter int unsigned SYNC_N    = 2,
  parameter int unsigned FALL_DLY  = 6,
  parameter int unsigned SW_WAIT   = 2,
  localparam int unsigned SUM_W    = CAL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  input  logic              sw_busy_i,
  input  logic [1:0]        sys_sel_i,
  input  logic [1:0]        tgt_sel_i,
  input  logic              pll_src_ext_i,
  input  logic              stop_i,
  input  logic              wake_i,
  input  logic              osc_fail_i,
  input  logic              int_stab_i,
  input  logic              ext_stab_i,
  input  logic              int_tick_i,
  input  logic [CAL_W-1:0]  cal_i,
  output logic              int_en_o,
  output logic              ext_en_o,
  output logic              int_rdy_o,
  output logic              ext_rdy_o,
  output logic [SUM_W-1:0]  trim_sum_o
);
  logic              wr;
  logic [TRIM_W-1:0] trim_q;
  logic [CAL_W-1:0]  cal_q;
  logic              cal_done_q;
  logic              int_sync, ext_sync;

  osc_bus_port #(.WAIT_N(SW_WAIT)) i_bus (
    .clk_i, .rst_ni, .req_i, .busy_i(sw_busy_i), .ack_o
  );

  assign wr = ack_o && we_i;

  osc_en_rules i_rules (
    .clk_i, .rst_ni, .wr_i(wr),
    .wr_int_i(wdata_i[BIT_INT_EN]), .wr_ext_i(wdata_i[BIT_EXT_EN]),
    .sys_sel_i, .tgt_sel_i, .pll_src_ext_i,
    .stop_i, .wake_i, .fail_i(osc_fail_i),
    .int_en_o, .ext_en_o
  );

  osc_sync #(.STAGES(SYNC_N)) i_sync_int (.clk_i, .rst_ni, .d_i(int_stab_i), .q_o(int_sync));
  osc_sync #(.STAGES(SYNC_N)) i_sync_ext (.clk_i, .rst_ni, .d_i(ext_stab_i), .q_o(ext_sync));

  osc_rdy_hold #(.DLY(FALL_DLY)) i_int_rdy (
    .clk_i, .rst_ni, .en_i(int_en_o), .stab_i(int_sync), .tick_i(int_tick_i), .rdy_o(int_rdy_o)
  );

  assign ext_rdy_o = ext_en_o && ext_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q     <= TRIM_W'(TRIM_RST);
      cal_q      <= '0;
      cal_done_q <= 1'b0;
    end else begin
      if (!cal_done_q) begin
        cal_q      <= cal_i;
        cal_done_q <= 1'b1;
      end
      if (wr) trim_q <= wdata_i[TRIM_LSB +: TRIM_W];
    end
  end

  assign trim_sum_o = SUM_W'(cal_q) + SUM_W'(trim_q);

  always_comb begin
    rdata_o                       = '0;
    rdata_o[BIT_INT_EN]           = int_en_o;
    rdata_o[BIT_INT_RDY]          = int_rdy_o;
    rdata_o[TRIM_LSB +: TRIM_W]   = trim_q;
    rdata_o[CAL_LSB +: CAL_W]     = cal_q;
    rdata_o[BIT_EXT_EN]           = ext_en_o;
    rdata_o[BIT_EXT_RDY]          = ext_rdy_o;
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:BIT_EXT_EN+1], wdata_i[CAL_LSB +: CAL_W],
                          wdata_i[2:1]};
endmodule

// File: rtl/osc_ctrl_chk.sv
module osc_ctrl_chk
  import osc_ctrl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [31:0] rdata_o,
  input logic        ack_o,
  input logic        sw_busy_i,
  input logic [1:0]  sys_sel_i,
  input logic [1:0]  tgt_sel_i,
  input logic        pll_src_ext_i,
  input logic        stop_i,
  input logic        wake_i,
  input logic        int_en_o,
  input logic        ext_en_o,
  input logic        int_rdy_o,
  input logic        ext_rdy_o,
  input logic [8:0]  trim_sum_o
);
  AST_INT_CLR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && we_i && osc_locked(sys_sel_i, tgt_sel_i, pll_src_ext_i, 1'b0)) |=> int_en_o); // R3
  AST_EXT_CLR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && we_i && !stop_i && osc_locked(sys_sel_i, tgt_sel_i, pll_src_ext_i, 1'b1)) |=> ext_en_o); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !ext_en_o); // R5
  AST_WAKE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> int_en_o); // R6
  AST_INT_RDY_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_en_o && $past(!int_en_o)) |-> !$rose(int_rdy_o)); // R7
  AST_EXT_RDY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rdy_o |-> ext_en_o); // R8
  AST_TRIM_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_sum_o == 9'(rdata_o[15:8]) + 9'(rdata_o[7:3])); // R9
  AST_SWITCH_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !$past(req_i) && sw_busy_i) |-> !ack_o); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[2] == 1'b0) && (rdata_o[31:18] == '0)); // R2
endmodule

bind osc_ctrl osc_ctrl_chk i_chk (.*);

// File: tb/test_osc_ctrl.sv
module test_osc_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        ack_o, sw_busy_i = 0;
  logic [1:0]  sys_sel_i = 2'b00, tgt_sel_i = 2'b00;
  logic        pll_src_ext_i = 0, stop_i = 0, wake_i = 0, osc_fail_i = 0;
  logic        int_stab_i = 0, ext_stab_i = 0, int_tick_i = 1;
  logic [7:0]  cal_i = 8'hF0;
  logic        int_en_o, ext_en_o, int_rdy_o, ext_rdy_o;
  logic [8:0]  trim_sum_o;

  int checks = 0, fails = 0;
  bit done = 0;
  localparam logic [7:0] CAL = 8'hF0;

  always #4 clk_i = ~clk_i;

  osc_ctrl i_osc_ctrl (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] d, output int waits, output logic [31:0] rd);
    waits = 0;
    @(negedge clk_i);
    req_i = 1; we_i = wr; wdata_i = d;
    forever begin
      #1;
      if (ack_o) break;
      waits++;
      @(negedge clk_i);
    end
    rd = rdata_o;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    #1;
  endtask

  task automatic wr(input logic [31:0] d);
    int w; logic [31:0] r;
    access(1'b1, d, w, r);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
    #1;
  endtask

  function automatic bit uses(input logic [1:0] s, input bit pe, input bit want_ext);
    if (s == 2'b00) return !want_ext;
    if (s == 2'b01) return want_ext;
    if (s == 2'b10) return pe == want_ext;
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w; logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    step(2);
    cal_i = 8'h11;
    // R1 reset values
    chk(rdata_o == 32'h0000_F081, "R1 reset rdata", rdata_o, 32'h0000_F081);
    chk(int_en_o && !ext_en_o && !int_rdy_o && !ext_rdy_o, "R1 reset outs",
        {int_en_o, ext_en_o, int_rdy_o, ext_rdy_o}, 4'b1000);
    chk(trim_sum_o == 9'd256, "R9 reset sum", trim_sum_o, 256);

    // R9 trim sweep, calibration frozen
    for (int t = 0; t < 32; t++) begin
      wr(32'(t << 3) | 32'h1 | 32'(8'h55 << 8));
      access(1'b0, 0, w, r);
      chk(r[7:3] == 5'(t) && r[15:8] == CAL, "R9 trim/cal readback", r, {CAL, 5'(t), 3'b001});
      chk(trim_sum_o == 9'(CAL) + 9'(t), "R9 sum", trim_sum_o, 9'(CAL) + 9'(t));
    end

    // R2 all-ones write, reserved bits zero, no wait
    access(1'b1, 32'hFFFF_FFFF, w, r);
    chk(w == 0, "R2 zero wait", w, 0);
    access(1'b0, 0, w, r);
    chk(r == 32'h0001_F0F9, "R2 layout", r, 32'h0001_F0F9);

    // R3 R4 lock sweep
    for (int s = 0; s < 3; s++)
      for (int g = 0; g < 3; g++)
        for (int p = 0; p < 2; p++) begin
          @(negedge clk_i);
          sys_sel_i = 2'(s); tgt_sel_i = 2'(g); pll_src_ext_i = p[0];
          wr(32'h0001_0081);
          wr(32'h0000_0080);
          chk(int_en_o == (uses(2'(s), p[0], 0) || uses(2'(g), p[0], 0)), "R3 int clear gate",
              int_en_o, uses(2'(s), p[0], 0) || uses(2'(g), p[0], 0));
          chk(ext_en_o == (uses(2'(s), p[0], 1) || uses(2'(g), p[0], 1)), "R4 ext clear gate",
              ext_en_o, uses(2'(s), p[0], 1) || uses(2'(g), p[0], 1));
        end

    // ready rise latencies, crystal in use
    @(negedge clk_i);
    sys_sel_i = 2'b01; tgt_sel_i = 2'b01; pll_src_ext_i = 1;
    wr(32'h0001_0081);
    @(negedge clk_i);
    int_stab_i = 1; ext_stab_i = 1;
    step(1);
    chk(!ext_rdy_o && !int_rdy_o, "R8 ready after 1 edge", {ext_rdy_o, int_rdy_o}, 0);
    step(1);
    chk(ext_rdy_o && !int_rdy_o, "R8 ext ready at edge 2", {ext_rdy_o, int_rdy_o}, 2'b10);
    step(1);
    chk(int_rdy_o, "R7 int ready at edge 3", int_rdy_o, 1);

    // R7 fall delay
    wr(32'h0001_0080);
    chk(!int_en_o && int_rdy_o, "R7 after clear", {int_en_o, int_rdy_o}, 2'b01);
    for (int k = 1; k <= 6; k++) begin
      step(1);
      chk(int_rdy_o == (k < 6), "R7 fall count", int_rdy_o, k < 6);
    end
    // R7 no ticks, hold
    wr(32'h0001_0081);
    step(1);
    chk(int_rdy_o, "R7 re-enabled", int_rdy_o, 1);
    @(negedge clk_i); int_tick_i = 0;
    wr(32'h0001_0080);
    step(20);
    chk(int_rdy_o, "R7 hold without ticks", int_rdy_o, 1);
    @(negedge clk_i); int_tick_i = 1;
    step(5);
    chk(int_rdy_o, "R7 tick 5", int_rdy_o, 1);
    step(1);
    chk(!int_rdy_o, "R7 tick 6", int_rdy_o, 0);

    // R6 failure forces RC on (direct, then via PLL)
    @(negedge clk_i); osc_fail_i = 1;
    @(negedge clk_i); osc_fail_i = 0; #1;
    chk(int_en_o, "R6 fail direct", int_en_o, 1);
    @(negedge clk_i); sys_sel_i = 2'b10; tgt_sel_i = 2'b10;
    wr(32'h0001_0080);
    chk(!int_en_o, "R3 unlocked clear", int_en_o, 0);
    @(negedge clk_i); osc_fail_i = 1;
    @(negedge clk_i); osc_fail_i = 0; #1;
    chk(int_en_o, "R6 fail via PLL", int_en_o, 1);

    // R6 wake, and wake beats a same-cycle clear
    wr(32'h0001_0080);
    @(negedge clk_i); wake_i = 1;
    @(negedge clk_i); wake_i = 0; #1;
    chk(int_en_o, "R6 wake", int_en_o, 1);
    @(negedge clk_i);
    wake_i = 1; req_i = 1; we_i = 1; wdata_i = 32'h0001_0080;
    @(negedge clk_i);
    wake_i = 0; req_i = 0; we_i = 0; #1;
    chk(int_en_o, "R6 wake over clear", int_en_o, 1);

    // R5 stop clears crystal even in use; R8 ready drops with it
    @(negedge clk_i); sys_sel_i = 2'b01; tgt_sel_i = 2'b01;
    wr(32'h0001_0081);
    chk(ext_en_o && ext_rdy_o, "R8 ext ready on", {ext_en_o, ext_rdy_o}, 2'b11);
    @(negedge clk_i); stop_i = 1;
    @(negedge clk_i); stop_i = 0; #1;
    chk(!ext_en_o && !ext_rdy_o, "R5 stop clear", {ext_en_o, ext_rdy_o}, 0);

    // R8 software clear drops ready at once
    @(negedge clk_i); sys_sel_i = 2'b00; tgt_sel_i = 2'b00;
    wr(32'h0001_0081);
    chk(ext_rdy_o, "R8 ready with enable", ext_rdy_o, 1);
    wr(32'h0000_0081);
    chk(!ext_rdy_o, "R8 ready after clear", ext_rdy_o, 0);

    // R10 wait states during switch
    @(negedge clk_i); sw_busy_i = 1;
    access(1'b1, 32'h0001_0081, w, r);
    chk(w == 2, "R10 write waits", w, 2);
    chk(ext_en_o, "R10 write applied", ext_en_o, 1);
    access(1'b0, 0, w, r);
    chk(w == 2, "R10 read waits", w, 2);
    @(negedge clk_i); sw_busy_i = 0;
    access(1'b0, 0, w, r);
    chk(w == 0, "R2 read no wait", w, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule